// File: doc/BRIEF.md
# Shared-Line Interrupt Collector

This block collects 32 interrupt request lines from peripherals and folds them onto 4 processor interrupt lines. Every request line first passes through a two-flop synchroniser. Its active sense is then set by a per-line polarity bit, and a per-line trigger bit selects whether it is caught as a level or as an edge. The result is held in one shared set of pending bits.

Each processor line has its own enable mask over all 32 sources. A processor line is asserted whenever any pending source that is enabled for it is set. Because the pending bits are kept apart from the masks, a source that fires while masked is not lost. It reaches the processor as soon as it is enabled, unless software cleared it in the meantime.

Software reaches the block through a 16-bit register bus with a byte address, a write strobe and a read strobe. Read data is combinational and is valid in the same cycle as the read strobe. The 32 sources are split into two 16-bit words: word 0 holds sources 0 to 15 and word 1 holds sources 16 to 31. Every control register exists once per word.

Top module: `irq_fanin_ctrl`

## Requirements
- R1: Bit b of word w belongs to source w*16+b. The pending bits of word w read at address w*0x40.
- R2: A change on a source line reaches the pending bit, and so the status read and the outputs, on the third rising clock edge after it is presented.
- R3: With the trigger bit at 0 (level), the pending bit follows the qualified level. A clear write has no lasting effect while the level stays active, and pending drops once the level goes away.
- R4: The polarity bits (word w at 0x30+w*0x40) set the active sense: 0 means active high and 1 means active low.
- R5: With the trigger bit at 1 (edge; word w at 0x20+w*0x40), the pending bit sets on an inactive-to-active transition of the qualified input. It stays set after the input returns to inactive.
- R6: A write to the clear register (0x10+w*0x40) clears every edge-mode pending bit whose data bit is 1 and leaves the bits written 0 unchanged. The clear register reads as 0.
- R7: When a new edge and a clear of the same source fall in the same cycle, the pending bit ends set.
- R8: The enable mask for word w and output n sits at 0x100+w*0x10+n*0x20. Output n is the OR over all sources of pending AND enable for n.
- R9: A masked source still sets its pending bit. Enabling it later asserts the output, unless the pending bit was cleared before the enable.
- R10: After reset all pending, enable, trigger and polarity bits are 0, so every source is level-sensitive and active high, and all outputs are low.
- R11: The trigger, polarity and enable registers read back what was written. Writes to a status address are ignored. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 32 | Asynchronous interrupt request lines |
| bus_addr | input | 9 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, combinational, 0 when not reading |
| irq_out | output | 4 | Processor interrupt lines |

## Verification
Some rules can be checked on every cycle, and the assertions cover these. They check that level-mode pending bits track the qualified input one cycle later, and that edge-mode bits rise only on a detected transition. They also check that a clear without a coincident edge drops the bit, that a coincident edge survives the clear, that an output is never high without an enabled pending source, and that the clear register reads 0.

Other behaviour needs whole scenarios, and only the bench can show it. This covers the address map and the word/bit placement of each source, the exact three-edge latency and the polarity inversion. It also covers the sequence of a masked source that fires and is enabled later, cleared or not, and the reset values of the registers.

// File: rtl/irq_fanin_ctrl.sv
module irq_fanin_ctrl #(
  parameter int WORD_W = 16,
  parameter int NWORD  = 2,
  parameter int NOUT   = 4,
  parameter int ADDR_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NWORD*WORD_W-1:0]   src_in,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [WORD_W-1:0]         bus_wdata,
  input  logic                      bus_we,
  input  logic                      bus_re,
  output logic [WORD_W-1:0]         bus_rdata,
  output logic [NOUT-1:0]           irq_out
);
  localparam int NSRC = NWORD * WORD_W;

  logic [NSRC-1:0] s1, s2, qd, pend, edge_sel, pol;
  logic [NSRC-1:0] q, evt, clr;
  logic [NOUT-1:0][NSRC-1:0] en;

  // decode: control space below 0x100, enable space from 0x100
  logic       ctl_hit, en_hit;
  logic       ctl_w, en_w;
  logic [1:0] ctl_kind, en_n;

  assign ctl_hit  = !bus_addr[8] && !bus_addr[7] && bus_addr[3:0] == 4'h0;
  assign ctl_w    = bus_addr[6];
  assign ctl_kind = bus_addr[5:4];
  assign en_hit   = bus_addr[8] && !bus_addr[7] && bus_addr[3:0] == 4'h0;
  assign en_w     = bus_addr[4];
  assign en_n     = bus_addr[6:5];

  assign q   = s2 ^ pol;
  assign evt = q & ~qd;

  always_comb begin
    clr = '0;
    if (bus_we && ctl_hit && ctl_kind == 2'd1)
      clr[ctl_w*WORD_W +: WORD_W] = bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      qd <= '0;
      pend <= '0;
    end else begin
      s1 <= src_in;
      s2 <= s1;
      qd <= q;
      pend <= (edge_sel & ((pend & ~clr) | evt)) | (~edge_sel & q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_sel <= '0;
      pol <= '0;
      en <= '0;
    end else if (bus_we) begin
      if (ctl_hit && ctl_kind == 2'd2) edge_sel[ctl_w*WORD_W +: WORD_W] <= bus_wdata;
      if (ctl_hit && ctl_kind == 2'd3) pol[ctl_w*WORD_W +: WORD_W] <= bus_wdata;
      if (en_hit) en[en_n][en_w*WORD_W +: WORD_W] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re && ctl_hit) begin
      case (ctl_kind)
        2'd0:    bus_rdata = pend[ctl_w*WORD_W +: WORD_W];
        2'd2:    bus_rdata = edge_sel[ctl_w*WORD_W +: WORD_W];
        2'd3:    bus_rdata = pol[ctl_w*WORD_W +: WORD_W];
        default: bus_rdata = '0;
      endcase
    end else if (bus_re && en_hit) begin
      bus_rdata = en[en_n][en_w*WORD_W +: WORD_W];
    end
  end

  for (genvar n = 0; n < NOUT; n++) begin : g_out
    assign irq_out[n] = |(pend & en[n]);
  end
endmodule

// File: rtl/irq_fanin_chk.sv
module irq_fanin_chk #(
  parameter int NSRC = 32,
  parameter int NOUT = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NSRC-1:0]           pend,
  input logic [NSRC-1:0]           edge_sel,
  input logic [NSRC-1:0]           q,
  input logic [NSRC-1:0]           evt,
  input logic [NSRC-1:0]           clr,
  input logic [NOUT-1:0][NSRC-1:0] en,
  input logic [NOUT-1:0]           irq_out,
  input logic                      bus_re,
  input logic [8:0]                bus_addr,
  input logic [15:0]               bus_rdata
);
  // R3
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(edge_sel)) & pend) == ((~$past(edge_sel)) & $past(q)));

  // R5
  edge_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & $past(edge_sel) & ~$past(evt)) == '0);

  // R6
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_sel) & $past(clr) & ~$past(evt) & pend) == '0);

  // R7
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_sel) & $past(evt) & ~pend) == '0);

  // R6
  clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !bus_addr[8] && !bus_addr[7] && bus_addr[5:4] == 2'd1
     && bus_addr[3:0] == 4'h0) |-> bus_rdata == '0);

  for (genvar n = 0; n < NOUT; n++) begin : g_irq
    // R8
    irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[n] |-> (pend & en[n]) != '0);
  end
endmodule

bind irq_fanin_ctrl irq_fanin_chk #(.NSRC(NSRC), .NOUT(NOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend), .edge_sel(edge_sel), .q(q),
  .evt(evt), .clr(clr), .en(en), .irq_out(irq_out), .bus_re(bus_re),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/irq_fanin_ctrl_bench.sv
module irq_fanin_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] src_in = '0;
  logic [8:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 0;
  logic        bus_re = 0;
  logic [15:0] bus_rdata;
  logic [3:0]  irq_out;

  int total = 0;
  int bad = 0;

  irq_fanin_ctrl u_irq_fanin_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {src, polarity, expected pending} level mode
  localparam logic [95:0] VEC [6] = '{
    {32'h0000_0001, 32'h0000_0000, 32'h0000_0001},
    {32'h8000_0000, 32'h0000_0000, 32'h8000_0000},
    {32'h0001_0000, 32'h0000_0000, 32'h0001_0000},
    {32'h0000_FFFF, 32'hFFFF_0000, 32'hFFFF_FFFF},
    {32'hA5A5_5A5A, 32'h0000_00FF, 32'hA5A5_5AA5},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [15:0] d);
    bus_addr = a; bus_re = 1;
    #1 d = bus_rdata;
    bus_re = 0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d, d1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset state
    rd(9'h020, d); check("R10 edge w0", {16'h0, d}, 0);
    rd(9'h070, d); check("R10 pol w1", {16'h0, d}, 0);
    rd(9'h170, d); check("R10 en w1 n3", {16'h0, d}, 0);
    rd(9'h000, d); check("R10 status w0", {16'h0, d}, 0);
    check("R10 irq", {28'h0, irq_out}, 0);

    // R1 R4 table walk
    for (int i = 0; i < 6; i++) begin
      wr(9'h030, VEC[i][47:32]);
      wr(9'h070, VEC[i][63:48]);
      src_in = VEC[i][95:64];
      settle();
      rd(9'h000, d); check("R1 R4 status w0", {16'h0, d}, {16'h0, VEC[i][15:0]});
      rd(9'h040, d); check("R1 R4 status w1", {16'h0, d}, {16'h0, VEC[i][31:16]});
    end
    wr(9'h030, 16'h0); wr(9'h070, 16'h0);
    src_in = '0; settle();

    // R2 latency
    src_in[3] = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(9'h000, d); check("R2 after two edges", {16'h0, d}, 0);
    @(posedge clk); @(negedge clk);
    rd(9'h000, d); check("R2 after three edges", {16'h0, d}, 32'h8);
    src_in[3] = 0; settle();

    // R3 level ignores clear while active
    src_in[2] = 1; settle();
    wr(9'h010, 16'h0004);
    rd(9'h000, d); check("R3 level after clear", {16'h0, d}, 32'h4);
    src_in[2] = 0; settle();
    rd(9'h000, d); check("R3 level drops", {16'h0, d}, 0);

    // R5 edge capture on source 5, R11 readback
    wr(9'h020, 16'h0020);
    rd(9'h020, d); check("R11 edge readback", {16'h0, d}, 32'h20);
    src_in[5] = 1; @(negedge clk); @(negedge clk);
    src_in[5] = 0; settle();
    rd(9'h000, d); check("R5 edge held", {16'h0, d}, 32'h20);

    // R6 clear semantics
    wr(9'h010, 16'h0000);
    rd(9'h000, d); check("R6 zero bits keep", {16'h0, d}, 32'h20);
    rd(9'h010, d); check("R6 clear reads zero", {16'h0, d}, 0);
    wr(9'h010, 16'h0020);
    rd(9'h000, d); check("R6 clear removes", {16'h0, d}, 0);

    // R6 word 1, source 20
    wr(9'h060, 16'h0010);
    src_in[20] = 1; @(negedge clk); @(negedge clk);
    src_in[20] = 0; settle();
    rd(9'h040, d); check("R6 w1 pend", {16'h0, d}, 32'h10);
    wr(9'h050, 16'h0010);
    rd(9'h040, d); check("R6 w1 cleared", {16'h0, d}, 0);

    // R7 edge and clear coincide
    src_in[5] = 1; @(negedge clk); @(negedge clk);
    src_in[5] = 0; settle();
    src_in[5] = 1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    wr(9'h010, 16'h0020);
    rd(9'h000, d); check("R7 edge wins", {16'h0, d}, 32'h20);
    src_in[5] = 0; settle();
    wr(9'h010, 16'h0020);

    // R9 masked source pends, R8 routing
    src_in[0] = 1; src_in[17] = 1; settle();
    check("R9 masked irq low", {28'h0, irq_out}, 0);
    rd(9'h000, d); check("R9 masked pends", {16'h0, d}, 32'h1);
    wr(9'h140, 16'h0001);
    check("R8 w0 n2", {28'h0, irq_out}, 32'h4);
    wr(9'h170, 16'h0002);
    check("R8 w1 n3", {28'h0, irq_out}, 32'hC);
    rd(9'h170, d); check("R11 enable readback", {16'h0, d}, 32'h2);
    src_in[0] = 0; src_in[17] = 0; settle();
    check("R8 all low", {28'h0, irq_out}, 0);

    // R9 cleared before enable stays quiet; uncleared one fires
    src_in[5] = 1; @(negedge clk); @(negedge clk);
    src_in[5] = 0; settle();
    wr(9'h010, 16'h0020);
    wr(9'h100, 16'h0020);
    check("R9 cleared no irq", {28'h0, irq_out}, 0);
    src_in[5] = 1; @(negedge clk); @(negedge clk);
    src_in[5] = 0; settle();
    check("R9 pending fires", {28'h0, irq_out}, 32'h1);

    // R11 status write ignored, unmapped reads zero
    wr(9'h000, 16'hFFFF);
    rd(9'h000, d); check("R11 status write ignored", {16'h0, d}, 32'h20);
    rd(9'h008, d); rd(9'h180, d1);
    check("R11 unmapped zero", {d, d1}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule